// File: doc/BRIEF.md
# LPC Mode-Entry Sequence Snooper

This block sits beside a host-side LPC decoder and watches the stream of I/O write cycles that the decoder has already separated out. Three four-write command sequences are recognised: enable-and-poll, switch-and-reset and exit-and-reset. Each one is a fixed list of address/data pairs set by parameters. A three-state controller (IDLE, READY, SWITCHED) reacts to these sequences. In SWITCHED, the host bus is routed to the internal flash interface and the embedded microcontroller is held in reset. In the other two states, the microcontroller runs and owns the flash.

The microcontroller can leave a one-bit "ready to hand over" flag in an 8-bit control register. When the host repeats enable-and-poll while the snooper is in READY, the flag is returned on the frame line. During the SYNC phase of the fourth write of that sequence, the block pulls LFRAME# low if the flag is set, and does not drive it otherwise. On entry to SWITCHED, hardware clears the flag. While SWITCHED lasts, software cannot set it again.

The block takes pre-decoded write events and a SYNC strobe as inputs. It leaves cycle framing, the flash command set and the tristate buffer itself to the surrounding logic.

Top module: `lpc_mode_snoop`

## Requirements
- R1: After reset, from any state, the block is in IDLE. `bus_to_flash`, `mcu_hold_rst` and `lframe_drive_low` are 0, and `cfg_rdata` reads 0x00.
- R2: In IDLE, a complete enable-and-poll sequence moves the block to READY. A switch-and-reset or exit-and-reset sequence leaves it in IDLE.
- R3: In READY, a complete enable-and-poll sequence keeps the block in READY. On the first `sync_strobe` after the fourth write, `lframe_drive_low` equals the ready flag (bit 7 of the control register).
- R4: In READY, a complete switch-and-reset sequence moves the block to SWITCHED. From the clock edge that takes the fourth write onward, `bus_to_flash` and `mcu_hold_rst` are both 1.
- R5: In READY, a complete exit-and-reset sequence returns the block to IDLE.
- R6: In SWITCHED, enable-and-poll and switch-and-reset sequences are ignored and the outputs stay high. Only exit-and-reset returns the block to IDLE, which drops both outputs.
- R7: `cfg_wr` loads bit 7 of `cfg_wdata` into the ready flag while the block is in IDLE or READY. Bits 6..0 are ignored and read back as 0.
- R8: The ready flag is cleared on the edge that enters SWITCHED. A `cfg_wr` while in SWITCHED leaves it at 0.
- R9: With the default parameters, every step of every sequence is an I/O write to address 0x00E4. The data bytes for steps 0..2 are 0x5A, 0xA5, 0x3C. The data byte for step 3 is 0x01 for enable-and-poll, 0x02 for switch-and-reset and 0x03 for exit-and-reset. A write that mismatches in address or data abandons a partial match. If that write equals step 0, it counts as step 0 of a new attempt.
- R10: `lframe_drive_low` is 1 only while `sync_strobe` is 1 and the block is in READY, and only for the SYNC that follows an enable-and-poll completed in READY. An enable-and-poll completed in IDLE never drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, merged from all reset sources |
| io_wr_valid | input | 1 | One-cycle pulse for each decoded LPC I/O write |
| io_wr_addr | input | AW (16) | I/O address of the write |
| io_wr_data | input | DW (8) | Data byte of the write |
| sync_strobe | input | 1 | One-cycle pulse during the SYNC phase of the latest write |
| cfg_wr | input | 1 | Microcontroller write strobe for the control register |
| cfg_wdata | input | REG_W (8) | Control register write data |
| cfg_rdata | output | REG_W (8) | Control register read data, with the flag at bit FLAG_BIT (7) |
| bus_to_flash | output | 1 | 1 routes the host bus to the internal flash interface |
| mcu_hold_rst | output | 1 | 1 holds the microcontroller in reset |
| lframe_drive_low | output | 1 | Enable for pulling LFRAME# low |

## Verification
The checker enforces several rules on every cycle. Frame drive appears only under a SYNC strobe in READY, and only with the flag set. The flag reads 0 throughout SWITCHED, including the first cycle. The control register's low bits never read back as 1. A cycle with no write never changes IDLE, READY or SWITCHED. The bench scenarios cover what the checker cannot see. These are the state reached for every pairing of start state and sequence, rejection of a sequence broken at each of its four steps, the restart-on-step-0 rule, and the poll answer for both flag values.

// File: rtl/lpc_snoop_pkg.sv
package lpc_snoop_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_READY    = 2'd1,
      ST_SWITCHED = 2'd2
   } snoop_state_e;

   localparam int NUM_SEQ = 3;
   localparam int SEQ_POLL = 0;
   localparam int SEQ_SWITCH = 1;
   localparam int SEQ_EXIT = 2;
endpackage

// File: rtl/lpc_seq_match.sv
module lpc_seq_match #(
   parameter int AW = 16,
   parameter int DW = 8,
   parameter int STEPS = 4,
   parameter bit RESTART_ON_FIRST = 1'b1,
   parameter logic [STEPS*AW-1:0] ADDRS = '0,
   parameter logic [STEPS*DW-1:0] DATAS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_evt,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          seq_hit
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   logic [CW-1:0] pos;
   logic          step_ok;
   logic          first_ok;
   logic [CW-1:0] pos_after_miss;

   always_comb begin
      step_ok  = (wr_addr == ADDRS[int'(pos)*AW +: AW]) &&
                 (wr_data == DATAS[int'(pos)*DW +: DW]);
      first_ok = (wr_addr == ADDRS[0 +: AW]) && (wr_data == DATAS[0 +: DW]);
      seq_hit  = wr_evt && step_ok && (pos == LAST);
   end

   // The restart policy after a broken write is a build-time choice.
   generate
      if (RESTART_ON_FIRST) begin : g_restart
         assign pos_after_miss = first_ok ? CW'(1) : '0;
      end else begin : g_plain
         assign pos_after_miss = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (wr_evt) begin
         if (step_ok) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
         end else begin
            pos <= pos_after_miss;
         end
      end
   end
endmodule

// File: rtl/lpc_ready_flag.sv
module lpc_ready_flag #(
   parameter int REG_W = 8,
   parameter int FLAG_BIT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             locked,
   input  logic             hw_clear,
   output logic             flag,
   output logic [REG_W-1:0] cfg_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hw_clear) begin
         flag <= 1'b0;
      end else if (cfg_wr && !locked) begin
         flag <= cfg_wdata[FLAG_BIT];
      end
   end

   always_comb begin
      cfg_rdata           = '0;
      cfg_rdata[FLAG_BIT] = flag;
   end
endmodule

// File: rtl/lpc_snoop_fsm.sv
module lpc_snoop_fsm
   import lpc_snoop_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_evt,
   input  logic         hit_poll,
   input  logic         hit_switch,
   input  logic         hit_exit,
   input  logic         sync_stb,
   input  logic         flag,
   output snoop_state_e state,
   output logic         enter_switched,
   output logic         frame_low
);
   snoop_state_e state_nx;
   logic         poll_armed;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (hit_poll) state_nx = ST_READY;
         ST_READY: begin
            if (hit_switch)    state_nx = ST_SWITCHED;
            else if (hit_exit) state_nx = ST_IDLE;
         end
         ST_SWITCHED: if (hit_exit) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   assign enter_switched = (state == ST_READY) && hit_switch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         poll_armed <= 1'b0;
      end else begin
         state <= state_nx;
         if (wr_evt) begin
            poll_armed <= (state == ST_READY) && hit_poll;
         end else if (sync_stb) begin
            poll_armed <= 1'b0;
         end
      end
   end

   assign frame_low = sync_stb && poll_armed && flag && (state == ST_READY);
endmodule

// File: rtl/lpc_mode_snoop.sv
module lpc_mode_snoop
   import lpc_snoop_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8,
   parameter int STEPS = 4,
   parameter int REG_W = 8,
   parameter int FLAG_BIT = 7,
   parameter bit RESTART_ON_FIRST = 1'b1,
   parameter logic [STEPS*AW-1:0] POLL_ADDRS   = {4{16'h00E4}},
   parameter logic [STEPS*DW-1:0] POLL_DATAS   = {8'h01, 8'h3C, 8'hA5, 8'h5A},
   parameter logic [STEPS*AW-1:0] SWITCH_ADDRS = {4{16'h00E4}},
   parameter logic [STEPS*DW-1:0] SWITCH_DATAS = {8'h02, 8'h3C, 8'hA5, 8'h5A},
   parameter logic [STEPS*AW-1:0] EXIT_ADDRS   = {4{16'h00E4}},
   parameter logic [STEPS*DW-1:0] EXIT_DATAS   = {8'h03, 8'h3C, 8'hA5, 8'h5A}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             io_wr_valid,
   input  logic [AW-1:0]    io_wr_addr,
   input  logic [DW-1:0]    io_wr_data,
   input  logic             sync_strobe,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   output logic             bus_to_flash,
   output logic             mcu_hold_rst,
   output logic             lframe_drive_low
);
   localparam int SA = STEPS * AW;
   localparam int SD = STEPS * DW;
   localparam logic [NUM_SEQ*SA-1:0] ALL_ADDRS = {EXIT_ADDRS, SWITCH_ADDRS, POLL_ADDRS};
   localparam logic [NUM_SEQ*SD-1:0] ALL_DATAS = {EXIT_DATAS, SWITCH_DATAS, POLL_DATAS};

   initial begin
      assert (STEPS >= 2) else $error("STEPS must be at least 2");
      assert (FLAG_BIT < REG_W) else $error("FLAG_BIT outside register");
      assert (AW >= 1 && DW >= 1) else $error("bad bus widths");
   end

   logic [NUM_SEQ-1:0] hits;
   snoop_state_e       state;
   logic               enter_switched;
   logic               flag;

   generate
      for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
         lpc_seq_match #(
            .AW(AW), .DW(DW), .STEPS(STEPS), .RESTART_ON_FIRST(RESTART_ON_FIRST),
            .ADDRS(ALL_ADDRS[g*SA +: SA]), .DATAS(ALL_DATAS[g*SD +: SD])
         ) i_match (
            .clk(clk), .rst_n(rst_n), .wr_evt(io_wr_valid),
            .wr_addr(io_wr_addr), .wr_data(io_wr_data), .seq_hit(hits[g])
         );
      end
   endgenerate

   lpc_snoop_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .wr_evt(io_wr_valid),
      .hit_poll(hits[SEQ_POLL]), .hit_switch(hits[SEQ_SWITCH]), .hit_exit(hits[SEQ_EXIT]),
      .sync_stb(sync_strobe), .flag(flag), .state(state),
      .enter_switched(enter_switched), .frame_low(lframe_drive_low)
   );

   lpc_ready_flag #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) i_flag (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .locked(state == ST_SWITCHED), .hw_clear(enter_switched),
      .flag(flag), .cfg_rdata(cfg_rdata)
   );

   assign bus_to_flash = (state == ST_SWITCHED);
   assign mcu_hold_rst = (state == ST_SWITCHED);
endmodule

// File: rtl/lpc_mode_snoop_chk.sv
module lpc_mode_snoop_chk
   import lpc_snoop_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int FLAG_BIT = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             io_wr_valid,
   input logic             sync_strobe,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             bus_to_flash,
   input logic             mcu_hold_rst,
   input logic             lframe_drive_low,
   input snoop_state_e     state
);
   localparam logic [REG_W-1:0] LOW_MASK = ~(REG_W'(1) << FLAG_BIT);

   // R10
   frame_only_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lframe_drive_low |-> (sync_strobe && state == ST_READY));
   // R3
   frame_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lframe_drive_low |-> cfg_rdata[FLAG_BIT]);
   // R7
   low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & LOW_MASK) == '0);
   // R8
   flag_clear_in_switched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_to_flash |-> !cfg_rdata[FLAG_BIT]);
   // R4
   hold_with_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_to_flash) |-> (mcu_hold_rst && $past(state) == ST_READY));
   // R6
   switched_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_to_flash && !io_wr_valid) |=> bus_to_flash);
   // R2
   idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !io_wr_valid) |=> state == ST_IDLE);
   // R5
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && !io_wr_valid) |=> state == ST_READY);
endmodule

bind lpc_mode_snoop lpc_mode_snoop_chk #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) i_chk (
   .clk(clk), .rst_n(rst_n), .io_wr_valid(io_wr_valid), .sync_strobe(sync_strobe),
   .cfg_rdata(cfg_rdata), .bus_to_flash(bus_to_flash), .mcu_hold_rst(mcu_hold_rst),
   .lframe_drive_low(lframe_drive_low), .state(state)
);

// File: tb/test_lpc_mode_snoop.sv
`timescale 1ns/1ps
module test_lpc_mode_snoop;
   localparam logic [15:0] PORT = 16'h00E4;
   localparam int POLL = 0, SWITCH = 1, EXIT = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic io_wr_valid = 1'b0, sync_strobe = 1'b0, cfg_wr = 1'b0;
   logic [15:0] io_wr_addr = '0;
   logic [7:0]  io_wr_data = '0, cfg_wdata = '0, cfg_rdata;
   logic bus_to_flash, mcu_hold_rst, lframe_drive_low;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lpc_mode_snoop i_lpc_mode_snoop (
      .clk(clk), .rst_n(rst_n), .io_wr_valid(io_wr_valid), .io_wr_addr(io_wr_addr),
      .io_wr_data(io_wr_data), .sync_strobe(sync_strobe), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_to_flash(bus_to_flash),
      .mcu_hold_rst(mcu_hold_rst), .lframe_drive_low(lframe_drive_low)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] seq_byte(int s, int k);
      case (k)
         0: return 8'h5A;
         1: return 8'hA5;
         2: return 8'h3C;
         default: return 8'(s + 1);
      endcase
   endfunction

   // Expected next state: 0 IDLE, 1 READY, 2 SWITCHED
   function automatic int next_st(int st, int s);
      if (st == 0) return (s == POLL) ? 1 : 0;
      if (st == 1) return (s == POLL) ? 1 : (s == SWITCH) ? 2 : 0;
      return (s == EXIT) ? 0 : 2;
   endfunction

   function automatic string req_of(int st, int s);
      if (st == 0) return "R2";
      if (st == 2) return "R6";
      return (s == POLL) ? "R3" : (s == SWITCH) ? "R4" : "R5";
   endfunction

   task automatic io_wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      io_wr_valid = 1'b1; io_wr_addr = a; io_wr_data = d;
      @(negedge clk);
      io_wr_valid = 1'b0;
   endtask

   task automatic send_seq(int s, int bad_step = -1);
      for (int k = 0; k < 4; k++)
         io_wr(PORT, seq_byte(s, k) ^ ((k == bad_step) ? 8'hFF : 8'h00));
   endtask

   task automatic sync_pulse(output bit drv);
      @(negedge clk);
      sync_strobe = 1'b1;
      #1 drv = lframe_drive_low;
      @(negedge clk);
      sync_strobe = 1'b0;
   endtask

   task automatic cfg_write(logic [7:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Reads the state at the ports; may move IDLE to READY as a side effect.
   task automatic probe(output int st);
      bit d;
      if (bus_to_flash) st = 2;
      else begin
         cfg_write(8'h80);
         send_seq(POLL);
         sync_pulse(d);
         st = d ? 1 : 0;
      end
   endtask

   initial begin
      int st;
      bit d;
      do_reset();
      // R1 reset state
      chk("R1 bus", bus_to_flash, 0);
      chk("R1 hold", mcu_hold_rst, 0);
      chk("R1 frame", lframe_drive_low, 0);
      chk("R1 rdata", cfg_rdata, 0);

      // R2..R6 sweep over start state and sequence
      for (int s0 = 0; s0 < 3; s0++) begin
         for (int s = 0; s < 3; s++) begin
            do_reset();
            if (s0 >= 1) send_seq(POLL);
            if (s0 == 2) send_seq(SWITCH);
            send_seq(s);
            chk({req_of(s0, s), " hold"}, mcu_hold_rst, next_st(s0, s) == 2);
            probe(st);
            chk({req_of(s0, s), " state"}, st, next_st(s0, s));
         end
      end

      // R1 reset out of SWITCHED
      do_reset(); send_seq(POLL); send_seq(SWITCH);
      do_reset();
      chk("R1 reset from switched", bus_to_flash, 0);

      // R3 poll answer for both flag values; R10 no drive without strobe
      do_reset(); send_seq(POLL);
      for (int f = 0; f < 2; f++) begin
         cfg_write(8'(f << 7));
         send_seq(POLL);
         sync_pulse(d);
         chk("R3 poll answer", d, f);
         #1 chk("R10 after strobe", lframe_drive_low, 0);
      end

      // R10 poll completed in IDLE never drives
      do_reset(); cfg_write(8'h80); send_seq(POLL); sync_pulse(d);
      chk("R10 idle poll", d, 0);

      // R7 register bit sweep in IDLE and READY
      do_reset();
      for (int v = 0; v < 256; v += 17) begin
         cfg_write(8'(v));
         chk("R7 idle rdata", cfg_rdata, v & 8'h80);
      end
      send_seq(POLL);
      cfg_write(8'hFF); chk("R7 ready rdata", cfg_rdata, 8'h80);
      cfg_write(8'h7F); chk("R7 ready low bits", cfg_rdata, 8'h00);

      // R8 flag cleared on entry, locked in SWITCHED
      cfg_write(8'h80);
      send_seq(SWITCH);
      chk("R8 cleared on entry", cfg_rdata, 0);
      chk("R4 route", bus_to_flash, 1);
      cfg_write(8'h80);
      chk("R8 write dropped", cfg_rdata, 0);
      send_seq(EXIT);
      chk("R6 exit route", bus_to_flash, 0);
      chk("R6 exit hold", mcu_hold_rst, 0);
      chk("R8 still clear", cfg_rdata, 0);

      // R9 break switch sequence at each step
      for (int k = 0; k < 4; k++) begin
         do_reset(); send_seq(POLL);
         send_seq(SWITCH, k);
         chk("R9 broken step", bus_to_flash, 0);
         send_seq(SWITCH);
         chk("R9 clean retry", bus_to_flash, 1);
      end
      // R9 wrong address aborts
      do_reset(); send_seq(POLL);
      io_wr(PORT, 8'h5A); io_wr(PORT + 16'd1, 8'hA5); io_wr(PORT, 8'h3C); io_wr(PORT, 8'h02);
      chk("R9 wrong address", bus_to_flash, 0);
      // R9 mismatch equal to step 0 restarts at step 1
      do_reset(); send_seq(POLL);
      io_wr(PORT, 8'h5A); io_wr(PORT, 8'hA5); io_wr(PORT, 8'h5A);
      io_wr(PORT, 8'hA5); io_wr(PORT, 8'h3C); io_wr(PORT, 8'h02);
      chk("R9 restart on step0", bus_to_flash, 1);
      // R9 plain mismatch does not restart
      do_reset(); send_seq(POLL);
      io_wr(PORT, 8'h5A); io_wr(PORT, 8'h00);
      io_wr(PORT, 8'hA5); io_wr(PORT, 8'h3C); io_wr(PORT, 8'h02);
      chk("R9 no restart", bus_to_flash, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule